// File: doc/BRIEF.md
# Processor Reset Supervisor

This block watches the health of a processor system and drives a pair of complementary reset outputs for it. Three conditions raise reset. The first is a brown-out flag from an external supply comparator. The second is an active-low push-button or logic reset line. The third is a watchdog that expires when the processor stops toggling its kick line. Once every fault has cleared, reset is held for a fixed stretch period and then released. A fault that arrives during the stretch starts the stretch over again.

The watchdog counts only while reset is released and while the kick line is marked as driven by a separate qualifier input. A floating kick line turns the watchdog off. When the line is driven again, counting starts from zero. The manual reset input passes through a counter-based glitch filter, so short low pulses are ignored. All three inputs cross into the clock domain through two flip-flops. All periods are parameters given in clock cycles, and the defaults suit a 125 MHz clock: a stretch of 210 ms, a watchdog period of 1.76 s and a filter of 1 µs.

The block has no data path, so every pin is a plain level signal with no handshake. "Edge n" below means the n-th rising clock edge after the input changes between edges.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_low` is 1 (1 = supply below threshold), `rst_out` is 1. After `supply_low` rises, `rst_out` rises on edge 3: two synchroniser stages and one output register.
- R2: After the last fault clears, reset releases exactly STRETCH_CYC edges after the last edge on which the internal fault was seen. For `supply_low` this means `rst_out` falls on edge STRETCH_CYC+2 after `supply_low` falls.
- R3: A fault that appears while reset is being stretched restarts the stretch. Release then follows only after the full period counted from the later fault.
- R4: While `sys_rst` is 1, `rst_out` is 1. After the last edge with `sys_rst` high, `rst_out` falls STRETCH_CYC edges later, provided no fault is present.
- R5: A low pulse on `mr_n` (0 = request reset) that spans fewer than MR_FILT_CYC edges has no effect on the outputs. A low pulse of MR_FILT_CYC or more edges raises `rst_out` on edge MR_FILT_CYC+3. Reset then releases STRETCH_CYC+3 edges after `mr_n` returns to 1.
- R6: Any change of `wd_kick`, rising or falling, clears the watchdog count. A change made no later than WDOG_CYC-3 cycles after reset released prevents expiry.
- R7: While `wd_driven` is 1 and `wd_kick` does not change, the watchdog expires and `rst_out` rises WDOG_CYC+1 edges after reset released. This reset is stretched like any other fault.
- R8: The watchdog count is held at zero while reset is asserted, whatever the cause. It starts counting on the first edge after release.
- R9: While `wd_driven` is 0 (the kick line is floating), the watchdog never expires. After `wd_driven` rises, counting starts from zero and, with no kick, `rst_out` rises on edge WDOG_CYC+3.
- R10: `rst_out_n` is always the inverse of `rst_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Synchronous block reset, active high; puts the outputs in reset and starts a stretch |
| supply_low | input | 1 | Brown-out flag from the supply comparator, 1 = supply low |
| mr_n | input | 1 | Manual reset request, active low |
| wd_kick | input | 1 | Watchdog kick; any change restarts the watchdog |
| wd_driven | input | 1 | 1 = kick line driven and watchdog enabled, 0 = kick line floating |
| rst_out | output | 1 | Processor reset, active high |
| rst_out_n | output | 1 | Processor reset, active low |

## Verification
The properties assume that `sys_rst` is held high for at least one edge before anything else happens, and that no input is unknown after that. They also assume that a qualifier change and a kick change never land in the same cycle, so that the re-enable point of the watchdog is well defined. The bench follows these rules: it drives every input to a known value before the first edge, keeps `sys_rst` high for three edges, and changes only one of `wd_driven` and `wd_kick` at any falling clock edge. Every expected edge of `rst_out` is placed in a queue with its cycle number, computed from the edge counts given in the requirements.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

  // Input bundle as it enters the synchroniser.
  typedef struct packed {
    logic supply_low;
    logic mr_n;
    logic kick;
    logic driven;
  } sup_in_t;

  // Values loaded into the synchroniser during block reset: no fault, watchdog off.
  localparam sup_in_t SUP_IN_IDLE = '{supply_low: 1'b0, mr_n: 1'b1, kick: 1'b0, driven: 1'b0};

  // Width of a counter that must hold 0 .. n-1.
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
  parameter int              W       = 4,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         sys_rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (sys_rst) begin
        meta[b] <= RST_VAL[b];
        q[b]    <= RST_VAL[b];
      end else begin
        meta[b] <= d[b];
        q[b]    <= meta[b];
      end
    end
  end

endmodule

// File: rtl/sup_mr_filter.sv
module sup_mr_filter #(
  parameter int FILT_CYC = 125
) (
  input  logic clk,
  input  logic sys_rst,
  input  logic mr_n_s,
  output logic fault
);

  localparam int            CW   = rst_sup_pkg::cnt_width(FILT_CYC);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] low_cnt;

  // The fault is raised only after FILT_CYC consecutive low samples.
  always_ff @(posedge clk) begin
    if (sys_rst || mr_n_s) begin
      low_cnt <= '0;
      fault   <= 1'b0;
    end else if (low_cnt == LAST) begin
      fault   <= 1'b1;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int WDOG_CYC = 220_000_000
) (
  input  logic                                         clk,
  input  logic                                         sys_rst,
  input  logic                                         hold,
  input  logic                                         driven,
  input  logic                                         kick,
  output logic                                         expire,
  output logic [rst_sup_pkg::cnt_width(WDOG_CYC)-1:0]  count
);

  localparam int            CW   = rst_sup_pkg::cnt_width(WDOG_CYC);
  localparam logic [CW-1:0] LAST = CW'(WDOG_CYC - 1);

  logic kick_q;
  logic toggled;

  always_ff @(posedge clk) begin
    if (sys_rst) kick_q <= 1'b0;
    else         kick_q <= kick;
  end

  assign toggled = kick ^ kick_q;

  // Cleared by reset, by a floating kick line, or by a kick edge. Expiry is a one-cycle pulse.
  always_ff @(posedge clk) begin
    if (sys_rst || hold || !driven || toggled) begin
      count  <= '0;
      expire <= 1'b0;
    end else if (count == LAST) begin
      count  <= '0;
      expire <= 1'b1;
    end else begin
      count  <= count + 1'b1;
      expire <= 1'b0;
    end
  end

endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int STRETCH_CYC = 26_250_000
) (
  input  logic clk,
  input  logic sys_rst,
  input  logic fault,
  output logic active
);

  localparam int            CW   = rst_sup_pkg::cnt_width(STRETCH_CYC);
  localparam logic [CW-1:0] LAST = CW'(STRETCH_CYC - 1);

  logic [CW-1:0] cnt;

  // Any fault reloads the stretch. Release comes STRETCH_CYC edges after the last fault edge.
  always_ff @(posedge clk) begin
    if (sys_rst || fault) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == LAST) begin
        cnt    <= '0;
        active <= 1'b0;
      end else begin
        cnt    <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int STRETCH_CYC = 26_250_000,
  parameter int WDOG_CYC    = 220_000_000,
  parameter int MR_FILT_CYC = 125
) (
  input  logic clk,
  input  logic sys_rst,
  input  logic supply_low,
  input  logic mr_n,
  input  logic wd_kick,
  input  logic wd_driven,
  output logic rst_out,
  output logic rst_out_n
);

  import rst_sup_pkg::*;

  localparam int WD_CW = cnt_width(WDOG_CYC);

  sup_in_t          raw_in;
  sup_in_t          sync_in;
  logic             low_s;
  logic             mr_s;
  logic             kick_s;
  logic             drv_s;
  logic             mr_fault;
  logic             wd_expire;
  logic [WD_CW-1:0] wd_count;
  logic             fault;
  logic             active;

  assign raw_in = '{supply_low: supply_low, mr_n: mr_n, kick: wd_kick, driven: wd_driven};

  sup_sync2 #(.W($bits(sup_in_t)), .RST_VAL(SUP_IN_IDLE)) u_sync (
    .clk     (clk),
    .sys_rst (sys_rst),
    .d       (raw_in),
    .q       (sync_in)
  );

  assign low_s  = sync_in.supply_low;
  assign mr_s   = sync_in.mr_n;
  assign kick_s = sync_in.kick;
  assign drv_s  = sync_in.driven;

  sup_mr_filter #(.FILT_CYC(MR_FILT_CYC)) u_mr_filter (
    .clk     (clk),
    .sys_rst (sys_rst),
    .mr_n_s  (mr_s),
    .fault   (mr_fault)
  );

  sup_wdog #(.WDOG_CYC(WDOG_CYC)) u_wdog (
    .clk     (clk),
    .sys_rst (sys_rst),
    .hold    (active),
    .driven  (drv_s),
    .kick    (kick_s),
    .expire  (wd_expire),
    .count   (wd_count)
  );

  assign fault = low_s | mr_fault | wd_expire;

  sup_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk     (clk),
    .sys_rst (sys_rst),
    .fault   (fault),
    .active  (active)
  );

  assign rst_out   = active;
  assign rst_out_n = ~active;

endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
  parameter int WDOG_CYC = 220_000_000
) (
  input logic                                         clk,
  input logic                                         sys_rst,
  input logic                                         low_s,
  input logic                                         mr_s,
  input logic                                         drv_s,
  input logic                                         mr_fault,
  input logic                                         wd_expire,
  input logic [rst_sup_pkg::cnt_width(WDOG_CYC)-1:0]  wd_count,
  input logic                                         rst_out
);

  p_supply_fault_r1: assert property (@(posedge clk) disable iff (sys_rst)
    low_s |=> rst_out);

  p_release_quiet_r2: assert property (@(posedge clk) disable iff (sys_rst)
    $fell(rst_out) |-> ($past(!low_s) && $past(!mr_fault) && $past(!wd_expire)));

  p_mr_filter_low_r5: assert property (@(posedge clk) disable iff (sys_rst)
    $rose(mr_fault) |-> $past(!mr_s));

  p_mr_fault_r5: assert property (@(posedge clk) disable iff (sys_rst)
    mr_fault |=> rst_out);

  p_wd_expire_r7: assert property (@(posedge clk) disable iff (sys_rst)
    wd_expire |=> rst_out);

  p_wd_held_r8: assert property (@(posedge clk) disable iff (sys_rst)
    rst_out |=> (wd_count == '0));

  p_wd_expire_released_r8: assert property (@(posedge clk) disable iff (sys_rst)
    wd_expire |-> !$past(rst_out));

  p_wd_float_r9: assert property (@(posedge clk) disable iff (sys_rst)
    !drv_s |=> (wd_count == '0 && !wd_expire));

endmodule

bind rst_supervisor rst_supervisor_chk #(.WDOG_CYC(WDOG_CYC)) i_rst_supervisor_chk (
  .clk       (clk),
  .sys_rst   (sys_rst),
  .low_s     (low_s),
  .mr_s      (mr_s),
  .drv_s     (drv_s),
  .mr_fault  (mr_fault),
  .wd_expire (wd_expire),
  .wd_count  (wd_count),
  .rst_out   (rst_out)
);

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;

  localparam int S = 20;
  localparam int W = 30;
  localparam int F = 4;

  typedef struct {
    int    cyc;
    bit    lvl;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic sys_rst = 1'b1;
  logic supply_low = 1'b0;
  logic mr_n = 1'b1;
  logic wd_kick = 1'b0;
  logic wd_driven = 1'b0;
  logic rst_out;
  logic rst_out_n;

  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;
  int   m_chk = 0, m_fail = 0;
  bit   mon_on = 1'b0;
  bit   last_lvl = 1'b1;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rst_supervisor #(.STRETCH_CYC(S), .WDOG_CYC(W), .MR_FILT_CYC(F)) i_rst_supervisor (
    .clk       (clk),
    .sys_rst   (sys_rst),
    .supply_low(supply_low),
    .mr_n      (mr_n),
    .wd_kick   (wd_kick),
    .wd_driven (wd_driven),
    .rst_out   (rst_out),
    .rst_out_n (rst_out_n)
  );

  // Monitor: pops an expected edge from the scoreboard each time rst_out changes.
  always @(negedge clk) begin
    if (mon_on) begin
      m_chk++;
      if (rst_out_n !== ~rst_out) begin
        m_fail++;
        $display("FAIL R10: rst_out_n=%b with rst_out=%b at cycle %0d, expected %b", rst_out_n, rst_out, cyc, ~rst_out);
      end
      if (rst_out !== last_lvl) begin
        m_chk++;
        if (sb.size() == 0) begin
          m_fail++;
          $display("FAIL unexpected edge (R2/R5/R9): rst_out=%b at cycle %0d, expected no change", rst_out, cyc);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (e.cyc != cyc || e.lvl != rst_out) begin
            m_fail++;
            $display("FAIL %s: rst_out=%b at cycle %0d, expected %b at cycle %0d", e.tag, rst_out, cyc, e.lvl, e.cyc);
          end
        end
        last_lvl = rst_out;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int c, input bit l, input string t);
    exp_t e;
    e.cyc = c;
    e.lvl = l;
    e.tag = t;
    sb.push_back(e);
  endtask

  task automatic check_lvl(input bit exp_v, input string t);
    n_chk++;
    if (rst_out !== exp_v) begin
      n_fail++;
      $display("FAIL %s: rst_out=%b at cycle %0d, expected %b", t, rst_out, cyc, exp_v);
    end
  endtask

  task automatic run_all();
    int e;
    // R4: reset state, then release after a full stretch
    tick(2);
    check_lvl(1'b1, "R4");
    tick(1);
    sys_rst = 1'b0;
    last_lvl = 1'b1;
    mon_on = 1'b1;
    push(cyc + S, 1'b0, "R4");
    tick(S + 5);
    // R1, R2: supply low pulse
    supply_low = 1'b1;
    push(cyc + 3, 1'b1, "R1");
    tick(5);
    supply_low = 1'b0;
    push(cyc + 2 + S, 1'b0, "R2");
    tick(S + 5);
    // R3: second fault inside the stretch restarts it
    supply_low = 1'b1;
    push(cyc + 3, 1'b1, "R3");
    tick(4);
    supply_low = 1'b0;
    tick(10);
    supply_low = 1'b1;
    tick(3);
    supply_low = 1'b0;
    push(cyc + 2 + S, 1'b0, "R3");
    tick(S + 5);
    // R5: glitch one cycle short of the filter length is ignored
    mr_n = 1'b0;
    tick(F - 1);
    mr_n = 1'b1;
    tick(10);
    check_lvl(1'b0, "R5");
    // R5: pulse of exactly the filter length is accepted
    mr_n = 1'b0;
    push(cyc + F + 3, 1'b1, "R5");
    tick(F);
    mr_n = 1'b1;
    push(cyc + 3 + S, 1'b0, "R5");
    tick(S + 5);
    // R9: enabling the watchdog starts it from zero
    wd_driven = 1'b1;
    push(cyc + W + 3, 1'b1, "R9");
    tick(W + 3);
    e = cyc + S;
    push(e, 1'b0, "R7");
    tick(S);
    // R7: no kick after release, so it expires again
    push(e + W + 1, 1'b1, "R7");
    tick(W + 1);
    e = cyc + S;
    push(e, 1'b0, "R7");
    tick(S);
    // R6: kicks at the latest allowed point keep reset released
    tick(W - 3);
    wd_kick = ~wd_kick;
    tick(W - 3);
    wd_kick = ~wd_kick;
    tick(10);
    check_lvl(1'b0, "R6");
    // R9: floating line disables the watchdog
    wd_driven = 1'b0;
    tick(3 * W);
    check_lvl(1'b0, "R9");
    // R8: watchdog held during a long supply fault, counts only after release
    wd_driven = 1'b1;
    supply_low = 1'b1;
    push(cyc + 3, 1'b1, "R8");
    tick(2 * W);
    supply_low = 1'b0;
    e = cyc + 2 + S;
    push(e, 1'b0, "R8");
    push(e + W + 1, 1'b1, "R8");
    push(e + W + 1 + S, 1'b0, "R8");
    tick(2 + S + W + 1 + S + 2);
    wd_driven = 1'b0;
    tick(10);
    check_lvl(1'b0, "R8");
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    mon_on = 1'b0;
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): cycle %0d reached, expected end before 20000", cyc);
    end
    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL %s: %0d expected edges left, first at cycle %0d, expected none", sb[0].tag, sb.size(), sb[0].cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk, n_fail + m_fail);
    $finish;
  end

endmodule